// File: doc/BRIEF.md
# Reliable Link Packet Retransmitter

This block is the sending half of a reliable point-to-point link. An upstream source hands it whole packets one byte per cycle. The block stores each packet in a small replay store and gives it the next 12-bit sequence number. It then emits a frame on a byte-wide output stream: two sequence bytes, the payload, and a 32-bit CRC. A packet stays in the store until the far end acknowledges it.

Acknowledgements come back on a separate input as a positive or negative indication, each carrying a sequence number. A positive one frees every stored packet up to and including that number. A negative one, or a period of silence from the far end, makes the block resend all outstanding packets, oldest first.

The first transmission of each packet spends one credit granted by the receiver. The number of packets in flight is therefore bounded both by the store depth and by those credits. Payloads are 1 to `MAX_LEN` bytes long. `DEPTH` and `MAX_LEN` are powers of two, and `MAX_LEN` is at least 4.

Top module: `lnk_replay_tx`

## Requirements
- R1: Sequence numbers are 12 bits wide. They start at 0 after reset, rise by one for each new packet accepted and wrap from 4095 to 0.
- R2: A frame is sent in this order: a byte holding `{4'b0, seq[11:8]}`, then `seq[7:0]`, then the payload bytes in the order they arrived, then 4 CRC bytes with the most significant byte first. `out_valid` stays high through the whole frame, and `out_last` marks the final CRC byte.
- R3: The CRC covers the two sequence bytes and the payload. It uses polynomial 0x04C11DB7, starts from all ones and shifts each byte in MSB first with no bit reflection. The remainder is inverted before it is sent.
- R4: The first transmission of a packet needs a credit and uses one up. Each cycle with `credit_inc` high adds one credit. The credit count starts at `INIT_CREDIT`.
- R5: The store holds up to `DEPTH` packets. `in_ready` is low while it is full.
- R6: An indication carrying sequence N, where N lies among the packets already sent and not yet acknowledged, frees every packet up to and including N. An N outside that window frees nothing.
- R7: A negative indication (`ack_nak` = 1) frees packets as R6 describes. It then resends every packet still outstanding, in ascending sequence order.
- R8: If packets are outstanding and `TIMEOUT` cycles pass with no packet freed and no replay started, all outstanding packets are resent.
- R9: The timer restarts when packets are freed or a replay begins. It is held at zero while nothing awaits acknowledgement.
- R10: `in_ready` is low during a replay, and resent frames use no credits.
- R11: When packets are freed in the same cycle as the timer expires, the freeing wins. The timer restarts and no replay starts.
- R12: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream payload byte valid |
| in_data | input | 8 | Upstream payload byte |
| in_last | input | 1 | Final byte of the upstream packet |
| in_ready | output | 1 | Block can take a payload byte |
| credit_inc | input | 1 | One credit granted by the receiver |
| ack_valid | input | 1 | Acknowledge indication present |
| ack_nak | input | 1 | 1 = negative, 0 = positive |
| ack_seq | input | 12 | Sequence number carried by the indication |
| out_valid | output | 1 | Frame byte valid |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of the frame |

## Verification
The interesting collision is a positive acknowledgement that frees a packet in the very cycle the replay timer expires. The bench sends two packets and counts edges from the last byte of the first frame. It raises the acknowledgement for that first packet exactly in the expiry cycle. The result is judged correct if no frame starts for nearly a whole further timeout and the one packet left is then resent by the restarted timer.

// File: rtl/lrt_pkg.sv
package lrt_pkg;
  localparam int SEQ_W = 12;
  typedef logic [SEQ_W-1:0] seq_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SHI,
    PH_SLO,
    PH_PAY,
    PH_CRC
  } phase_e;

  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  // Fold one byte into the running remainder, most significant bit first.
  function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] b);
    logic [31:0] c;
    c = c_in ^ {b, 24'h0};
    for (int i = 0; i < 8; i++) begin
      c = c[31] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/rpl_store.sv
module rpl_store #(
  parameter int DEPTH   = 4,
  parameter int MAX_LEN = 8,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PI_W   = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_slot,
  input  logic [PI_W-1:0]  wr_idx,
  input  logic [7:0]       wr_data,
  input  logic             len_we,
  input  logic [IDX_W-1:0] rd_slot,
  input  logic [PI_W-1:0]  rd_idx,
  output logic [7:0]       rd_data,
  output logic [PI_W-1:0]  rd_lenm1
);
  logic [7:0]      mem_q   [DEPTH][MAX_LEN];
  logic [PI_W-1:0] lenm1_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_slot][wr_idx] <= wr_data;
  end

  // Per-slot length register, written with the index of the final byte.
  for (genvar g = 0; g < DEPTH; g++) begin : g_len
    logic sel;
    assign sel = len_we && (wr_slot == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (sel) lenm1_q[g] <= wr_idx;
    end
  end

  assign rd_data  = mem_q[rd_slot][rd_idx];
  assign rd_lenm1 = lenm1_q[rd_slot];
endmodule

// File: rtl/rpl_crc.sv
module rpl_crc (
  input  logic [31:0] crc_in,
  input  logic [7:0]  data,
  output logic [31:0] crc_out
);
  import lrt_pkg::*;
  always_comb crc_out = crc_step(crc_in, data);
endmodule

// File: rtl/rpl_timer.sv
module rpl_timer #(
  parameter int LIMIT = 1024,
  localparam int TW   = $clog2(LIMIT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic expire
);
  logic [TW-1:0] cnt_q, cnt_d;

  assign expire = run && (cnt_q == TW'(LIMIT - 1));

  always_comb begin
    if (!run || restart || expire) cnt_d = '0;
    else                           cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_tmr_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TW'(LIMIT - 1));
  p_tmr_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/lnk_replay_tx.sv
module lnk_replay_tx #(
  parameter int DEPTH       = 4,
  parameter int MAX_LEN     = 8,
  parameter int TIMEOUT     = 1024,
  parameter int CR_W        = 4,
  parameter int INIT_CREDIT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        in_ready,
  input  logic        credit_inc,
  input  logic        ack_valid,
  input  logic        ack_nak,
  input  logic [11:0] ack_seq,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last
);
  import lrt_pkg::*;

  localparam int IDX_W = $clog2(DEPTH);
  localparam int PI_W  = $clog2(MAX_LEN);
  localparam seq_t DEPTH_S = seq_t'(DEPTH);
  localparam logic [CR_W-1:0] CR_MAX = '1;
  localparam logic [PI_W-1:0] CRC_LAST = PI_W'(3);

  // Reset: asserted at once, released on a clock edge.
  logic rs1_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q   <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rs1_q   <= 1'b1;
      rst_s_n <= rs1_q;
    end
  end

  seq_t head_q, head_d, sent_q, sent_d, tail_q, tail_d, rp_q, rp_d, cur_q, cur_d;
  phase_e ph_q, ph_d;
  logic [PI_W-1:0] cnt_q, cnt_d, wcnt_q, wcnt_d;
  logic cur_new_q, cur_new_d, rpl_q, rpl_d, req_q, req_d;
  logic [CR_W-1:0] credit_q, credit_d;
  logic [31:0] crc_q, crc_d, crc_nx;

  logic [7:0]      rd_data;
  logic [PI_W-1:0] rd_lenm1;
  logic wr, full, ack_hit, outst_nx, run, expire, exp_eff, rstart, take, frame_end;
  seq_t head_nx, occ, win, ack_off;
  logic [31:0] crc_inv;

  // Occupancy, acknowledge window and the input side.
  assign occ      = tail_q - head_q;
  assign win      = sent_q - head_q;
  assign full     = (occ == DEPTH_S);
  assign in_ready = !full && !rpl_q;
  assign wr       = in_valid && in_ready;
  assign ack_off  = ack_seq - head_q;
  assign ack_hit  = ack_valid && (ack_off < win);
  assign head_nx  = ack_hit ? (ack_seq + seq_t'(1)) : head_q;
  assign outst_nx = (head_nx != sent_q);
  assign run      = (sent_q != head_q);
  assign exp_eff  = expire && !ack_hit;

  rpl_store #(.DEPTH(DEPTH), .MAX_LEN(MAX_LEN)) u_store (
    .clk     (clk),
    .wr_en   (wr),
    .wr_slot (tail_q[IDX_W-1:0]),
    .wr_idx  (wcnt_q),
    .wr_data (in_data),
    .len_we  (wr && in_last),
    .rd_slot (cur_q[IDX_W-1:0]),
    .rd_idx  (cnt_q),
    .rd_data (rd_data),
    .rd_lenm1(rd_lenm1)
  );

  rpl_crc u_crc (.crc_in(crc_q), .data(out_data), .crc_out(crc_nx));

  rpl_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .run    (run),
    .restart(ack_hit || rstart),
    .expire (expire)
  );

  // Output byte selection.
  assign crc_inv   = ~crc_q;
  assign out_valid = (ph_q != PH_IDLE);
  assign out_last  = (ph_q == PH_CRC) && (cnt_q == CRC_LAST);
  assign frame_end = out_last;

  always_comb begin
    case (ph_q)
      PH_SHI:  out_data = 8'(cur_q >> 8);
      PH_SLO:  out_data = cur_q[7:0];
      PH_PAY:  out_data = rd_data;
      PH_CRC: begin
        case (cnt_q[1:0])
          2'd0:    out_data = crc_inv[31:24];
          2'd1:    out_data = crc_inv[23:16];
          2'd2:    out_data = crc_inv[15:8];
          default: out_data = crc_inv[7:0];
        endcase
      end
      default: out_data = 8'h00;
    endcase
  end

  // Next-state logic: input write pointer, framing sequencer, replay control.
  always_comb begin
    head_d    = head_nx;
    tail_d    = tail_q;
    wcnt_d    = wcnt_q;
    sent_d    = sent_q;
    rp_d      = rp_q;
    cur_d     = cur_q;
    cur_new_d = cur_new_q;
    ph_d      = ph_q;
    cnt_d     = cnt_q;
    crc_d     = crc_q;
    rpl_d     = rpl_q;
    rstart    = 1'b0;
    take      = 1'b0;

    if (wr) begin
      if (in_last) begin
        tail_d = tail_q + seq_t'(1);
        wcnt_d = '0;
      end else begin
        wcnt_d = wcnt_q + PI_W'(1);
      end
    end

    case (ph_q)
      PH_IDLE: begin
        if (rpl_q) begin
          if (rp_q != sent_q) begin
            ph_d = PH_SHI; cur_d = rp_q; cur_new_d = 1'b0; crc_d = '1;
            rp_d = rp_q + seq_t'(1);
          end else begin
            rpl_d = 1'b0;
          end
        end else if (req_q && outst_nx) begin
          rpl_d  = 1'b1;
          rstart = 1'b1;
          ph_d = PH_SHI; cur_d = head_nx; cur_new_d = 1'b0; crc_d = '1;
          rp_d = head_nx + seq_t'(1);
        end else if ((sent_q != tail_q) && (credit_q != '0)) begin
          take = 1'b1;
          ph_d = PH_SHI; cur_d = sent_q; cur_new_d = 1'b1; crc_d = '1;
        end
      end
      PH_SHI: begin
        ph_d  = PH_SLO;
        crc_d = crc_nx;
      end
      PH_SLO: begin
        ph_d  = PH_PAY;
        cnt_d = '0;
        crc_d = crc_nx;
      end
      PH_PAY: begin
        crc_d = crc_nx;
        if (cnt_q == rd_lenm1) begin
          ph_d  = PH_CRC;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + PI_W'(1);
        end
      end
      PH_CRC: begin
        if (frame_end) begin
          ph_d = PH_IDLE;
          if (cur_new_q) sent_d = sent_q + seq_t'(1);
        end else begin
          cnt_d = cnt_q + PI_W'(1);
        end
      end
      default: ph_d = PH_IDLE;
    endcase

    req_d = (req_q || (ack_valid && ack_nak) || exp_eff) && outst_nx && !rstart;

    credit_d = credit_q;
    if (credit_inc && !take && (credit_q != CR_MAX)) credit_d = credit_q + CR_W'(1);
    else if (take && !credit_inc)                    credit_d = credit_q - CR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      head_q    <= '0;
      sent_q    <= '0;
      tail_q    <= '0;
      rp_q      <= '0;
      cur_q     <= '0;
      wcnt_q    <= '0;
      cnt_q     <= '0;
      cur_new_q <= 1'b0;
      rpl_q     <= 1'b0;
      req_q     <= 1'b0;
      ph_q      <= PH_IDLE;
      crc_q     <= '1;
      credit_q  <= CR_W'(INIT_CREDIT);
    end else begin
      head_q    <= head_d;
      sent_q    <= sent_d;
      tail_q    <= tail_d;
      rp_q      <= rp_d;
      cur_q     <= cur_d;
      wcnt_q    <= wcnt_d;
      cnt_q     <= cnt_d;
      cur_new_q <= cur_new_d;
      rpl_q     <= rpl_d;
      req_q     <= req_d;
      ph_q      <= ph_d;
      crc_q     <= crc_d;
      credit_q  <= credit_d;
    end
  end

  // Sequence counters only ever advance by one.
  p_sent_step_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    sent_q != $past(sent_q) |-> sent_q == $past(sent_q) + seq_t'(1));
  p_tail_step_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    tail_q != $past(tail_q) |-> tail_q == $past(tail_q) + seq_t'(1));
  // Store never holds more than its depth.
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (tail_q - head_q) <= DEPTH_S);
  // Sent-but-unacknowledged window lies inside the stored packets.
  p_window_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sent_q - head_q) <= (tail_q - head_q));
  // A replay leaves the credit count alone.
  p_replay_credit_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rpl_q && !credit_inc) |=> credit_q == $past(credit_q));
  // A frame only ends after its marked final byte.
  p_frame_end_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(out_valid) |-> $past(out_last));
endmodule

// File: tb/lnk_replay_tx_bench.sv
module lnk_replay_tx_bench;
  localparam int DEPTH = 4;
  localparam int MAXL  = 8;
  localparam int TMO   = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, credit_inc = 1'b0;
  logic ack_valid = 1'b0, ack_nak = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [11:0] ack_seq = 12'h000;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_data;

  always #10 clk = ~clk;

  lnk_replay_tx #(.DEPTH(DEPTH), .MAX_LEN(MAXL), .TIMEOUT(TMO), .CR_W(4), .INIT_CREDIT(2))
  u_lnk_replay_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .credit_inc(credit_inc), .ack_valid(ack_valid), .ack_nak(ack_nak),
    .ack_seq(ack_seq), .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  int nchk = 0, nerr = 0, starts = 0;
  logic [7:0] fb[$];
  int seen[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {fb[i], 24'h0};
      for (int k = 0; k < 8; k++) c = c[31] ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
    end
    return ~c;
  endfunction

  // Frame monitor: format (R2) and CRC (R3) against the bench's own pattern.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (fb.size() == 0) starts++;
      fb.push_back(out_data);
      if (out_last) begin
        int n, s, plen;
        bit ok;
        logic [31:0] got, exp;
        n = fb.size();
        s = {fb[0][3:0], fb[1]};
        plen = s % MAXL + 1;
        ok = (fb[0][7:4] == 4'h0) && (n == plen + 6);
        if (ok) for (int i = 0; i < plen; i++) if (fb[2+i] != 8'(s*7 + i + 3)) ok = 0;
        chk(ok, "R2 frame layout", n, plen + 6);
        if (n >= 6) begin
          got = {fb[n-4], fb[n-3], fb[n-2], fb[n-1]};
          exp = ref_crc(n - 4);
          chk(got == exp, "R3 crc", got, exp);
        end
        seen.push_back(s);
        fb.delete();
      end
    end
  end

  task automatic send_pkt(input int s);
    int n = s % MAXL + 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'(s*7 + i + 3); in_last = (i == n - 1);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic give_credit();
    @(negedge clk); credit_inc = 1'b1;
    @(negedge clk); credit_inc = 1'b0;
  endtask

  task automatic send_ack(input int s, input bit nak);
    @(negedge clk); ack_valid = 1'b1; ack_nak = nak; ack_seq = 12'(s);
    @(negedge clk); ack_valid = 1'b0; ack_nak = 1'b0;
  endtask

  task automatic get_frame(output int s);
    while (seen.size() == 0) @(negedge clk);
    s = seen.pop_front();
  endtask

  task automatic wait_last();
    @(negedge clk);
    while (!(out_valid && out_last)) @(negedge clk);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    int s, f0, k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12: reset state
    chk(out_valid == 1'b0, "R12 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R12 in_ready", in_ready, 1);

    // R1: first numbers, two credits available
    send_pkt(0); send_pkt(1);
    get_frame(s); chk(s == 0, "R1 first seq", s, 0);
    get_frame(s); chk(s == 1, "R1 second seq", s, 1);

    // R4: no credit, no transmission; grant one and it goes
    send_pkt(2);
    f0 = starts;
    repeat (40) @(negedge clk);
    chk(starts == f0, "R4 held without credit", starts, f0);
    give_credit();
    get_frame(s); chk(s == 2, "R4 sent after credit", s, 2);

    // R5: fill the store
    give_credit();
    send_pkt(3);
    chk(in_ready == 1'b0, "R5 full blocks input", in_ready, 0);
    get_frame(s); chk(s == 3, "R1 fourth seq", s, 3);
    // R6: out-of-window indication frees nothing
    send_ack(100, 1'b0);
    @(negedge clk);
    chk(in_ready == 1'b0, "R6 out-of-window ignored", in_ready, 0);
    // R6: in-window ACK frees seq 0
    send_ack(0, 1'b0);
    @(negedge clk);
    chk(in_ready == 1'b1, "R6 ack frees", in_ready, 1);

    // R7/R10: a spare credit, then NAK 1 -> frees 1, replays 2 and 3
    give_credit();
    send_ack(1, 1'b1);
    while (!out_valid) @(negedge clk);
    chk(in_ready == 1'b0, "R10 input blocked in replay", in_ready, 0);
    get_frame(s); chk(s == 2, "R7 replay first", s, 2);
    get_frame(s); chk(s == 3, "R7 replay order", s, 3);
    send_pkt(4);
    get_frame(s); chk(s == 4, "R10 credit kept through replay", s, 4);
    send_ack(4, 1'b0);
    repeat (3) @(negedge clk);

    // R8/R9: timeout replay measured from the frame end
    seen.delete();
    give_credit();
    send_pkt(5);
    wait_last();
    k = 0;
    @(negedge clk);
    while (!out_valid) begin k++; @(negedge clk); end
    chk(k >= TMO && k <= TMO + 3, "R8 timeout interval", k, TMO);
    get_frame(s); get_frame(s);
    chk(s == 5, "R8 timeout replays", s, 5);
    send_ack(5, 1'b0);
    repeat (3) @(negedge clk);

    // R11: ACK in the expiry cycle wins over the timer
    seen.delete();
    give_credit(); give_credit();
    send_pkt(6); send_pkt(7);
    wait_last();
    @(posedge clk);
    repeat (TMO - 1) @(posedge clk);
    @(negedge clk); ack_valid = 1'b1; ack_nak = 1'b0; ack_seq = 12'd6;
    @(negedge clk); ack_valid = 1'b0;
    f0 = starts;
    repeat (TMO - 10) @(negedge clk);
    chk(starts == f0, "R11 no replay on collision", starts, f0);
    get_frame(s); get_frame(s); get_frame(s);
    chk(s == 7, "R9 restarted timer replays rest", s, 7);
    send_ack(7, 1'b0);
    repeat (3) @(negedge clk);
    seen.delete();

    // R1: run past the wrap of the sequence space
    for (int n = 8; n < 4100; n++) begin
      give_credit();
      send_pkt(n % 4096);
      get_frame(s);
      chk(s == n % 4096, "R1 sequence and wrap", s, n % 4096);
      send_ack(n % 4096, 1'b0);
    end

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule